// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used virtual-to-physical page mappings and translates addresses against them. A requester presents a virtual page number, a page offset and a write flag. The page number is compared with every valid entry at once. On a match, the block returns the physical address one cycle later. That address is the stored frame number placed above the unchanged offset. Each entry carries a reference bit and a dirty bit, and accesses set them.

When no entry matches, the block raises a one-cycle miss pulse and stops accepting lookups. An external page-table walker then supplies the frame number. The block installs the mapping in a victim slot and returns the translated address. If the slot it overwrote held a live mapping, the block also exports that mapping together with its dirty and reference bits. The walker can use them to update the page table.

A synchronous flush discards every mapping in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous reset, no entry is valid, `ready` is 1, and `rsp_valid`, `miss` and `evict_valid` are 0.
- R2: A lookup accepted at a clock edge (`req_valid` high, `ready` high, `flush` low) that matches a valid entry drives `rsp_valid`=1 in the next cycle. In that cycle `rsp_pa` = {stored frame number, `req_off`}, with the frame number in the upper `PPN_W` bits.
- R3: A matching lookup sets that entry's reference bit, and a matching lookup with `req_write`=1 also sets its dirty bit. A dirty bit stays set until the entry is replaced.
- R4: An accepted lookup that matches no valid entry drives `miss`=1 for exactly one cycle, with `miss_vpn` equal to the missing page number. `rsp_valid` stays 0 in that cycle, and `ready` falls in the same cycle.
- R5: While waiting, a cycle with `fill_valid`=1 installs {missing page, `fill_ppn`}. In the next cycle `rsp_valid`=1, `rsp_pa`={`fill_ppn`, offset of the missing lookup} and `ready`=1.
- R6: A newly installed entry has its reference bit set, and its dirty bit set only if the missing lookup was a write.
- R7: The victim is the lowest-numbered invalid entry if one exists. Otherwise it is the entry named by a round-robin pointer. That pointer starts at 0 after reset and advances by one, modulo `ENTRIES`, on each refill that finds every entry valid.
- R8: In the cycle after a refill, `evict_valid` is 1 exactly when the victim held a valid mapping. In that case `evict_vpn`, `evict_ppn`, `evict_ref` and `evict_dirty` carry the victim's old contents.
- R9: `flush`=1 invalidates every entry by the next cycle without exporting anything. A lookup presented in a flush cycle is dropped and gives neither a response nor a miss.
- R10: While a refill is pending, `ready` is 0 and `req_valid` is ignored: no response and no further miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset, passed through |
| req_write | input | 1 | Lookup is for a write access |
| ready | output | 1 | Lookups are accepted |
| rsp_valid | output | 1 | Translated address is valid |
| rsp_pa | output | PPN_W+OFF_W | Physical address |
| miss | output | 1 | One-cycle miss pulse |
| miss_vpn | output | VPN_W | Page number that missed |
| fill_valid | input | 1 | Walker delivers a mapping |
| fill_ppn | input | PPN_W | Frame number for the missing page |
| evict_valid | output | 1 | A live mapping was replaced |
| evict_vpn | output | VPN_W | Replaced page number |
| evict_ppn | output | PPN_W | Replaced frame number |
| evict_ref | output | 1 | Replaced entry's reference bit |
| evict_dirty | output | 1 | Replaced entry's dirty bit |

## Verification
Embedded properties check the following on every cycle:
- at most one entry ever matches a page number;
- the miss pulse lasts one cycle and leaves `ready` low;
- a response and a miss never coincide;
- flush empties the valid vector;
- a free slot is always preferred as victim;
- a hit leaves the reference bit (and, for writes, the dirty bit) set.

Only the bench's scenarios can show that the returned addresses and exported victims are correct. A reference model predicts the round-robin order after the buffer fills, dirty bits gathered from earlier write hits, lookups dropped during a flush or a pending refill, and refills into slots freed by a flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lookup_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [VPN_W-1:0]   rd_vpn,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign valid_vec = valid_q;
  assign rd_vpn    = vpn_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (flush) valid_q <= '0;
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) vpn_q[wr_idx] <= wr_vpn;
  end

  // R2: a page number never matches more than one slot
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R9: flush leaves no valid slot unless a refill lands in the same cycle
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    (flush && !wr_en) |=> (valid_q == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (advance && !any_free) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // R7: while a free slot exists the victim is never a live slot
  a_r7_prefer_free: assert property (@(posedge clk) disable iff (rst)
    (!(&valid_vec)) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/xlat_data_array.sv
module xlat_data_array #(
  parameter int ENTRIES = 64,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_upd,
  input  logic             hit_wr,
  input  logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_dirty,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_ref,
  output logic             rd_dirty
);
  logic [PPN_W-1:0]   ppn_mem [ENTRIES];
  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) ppn_mem[wr_idx] <= wr_ppn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      ref_q[wr_idx]   <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end else if (hit_upd) begin
      ref_q[hit_idx] <= 1'b1;
      if (hit_wr) dirty_q[hit_idx] <= 1'b1;
    end
  end

  assign hit_ppn  = ppn_mem[hit_idx];
  assign rd_ppn   = ppn_mem[rd_idx];
  assign rd_ref   = ref_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  // R3: a hit leaves the reference bit of the matched slot set
  a_r3_ref_on_hit: assert property (@(posedge clk) disable iff (rst)
    hit_upd |=> ref_q[$past(hit_idx)]);

  // R3: a write hit leaves the dirty bit of the matched slot set
  a_r3_dirty_on_write: assert property (@(posedge clk) disable iff (rst)
    (hit_upd && hit_wr) |=> dirty_q[$past(hit_idx)]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   req_write,
  output logic                   ready,
  output logic                   rsp_valid,
  output logic [PPN_W+OFF_W-1:0] rsp_pa,
  output logic                   miss,
  output logic [VPN_W-1:0]       miss_vpn,
  input  logic                   fill_valid,
  input  logic [PPN_W-1:0]       fill_ppn,
  output logic                   evict_valid,
  output logic [VPN_W-1:0]       evict_vpn,
  output logic [PPN_W-1:0]       evict_ppn,
  output logic                   evict_ref,
  output logic                   evict_dirty
);
  import xlat_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xlat_state_e        state_q;
  logic [VPN_W-1:0]   pend_vpn;
  logic [OFF_W-1:0]   pend_off;
  logic               pend_wr;

  logic               accept;
  logic               fill_take;
  logic               tag_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               victim_live;
  logic [VPN_W-1:0]   victim_vpn;
  logic [PPN_W-1:0]   victim_ppn;
  logic               victim_ref;
  logic               victim_dirty;

  assign ready       = (state_q == ST_IDLE);
  assign accept      = req_valid && ready && !flush;
  assign fill_take   = (state_q == ST_WAIT) && fill_valid;
  assign victim_live = valid_vec[victim_idx];

  xlat_tag_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .lookup_vpn(req_vpn),
    .wr_en     (fill_take),
    .wr_idx    (victim_idx),
    .wr_vpn    (pend_vpn),
    .rd_idx    (victim_idx),
    .rd_vpn    (victim_vpn),
    .valid_vec (valid_vec),
    .hit       (tag_hit),
    .hit_idx   (hit_idx)
  );

  xlat_data_array #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .hit_upd (accept && tag_hit),
    .hit_wr  (req_write),
    .hit_idx (hit_idx),
    .hit_ppn (hit_ppn),
    .wr_en   (fill_take),
    .wr_idx  (victim_idx),
    .wr_ppn  (fill_ppn),
    .wr_dirty(pend_wr),
    .rd_idx  (victim_idx),
    .rd_ppn  (victim_ppn),
    .rd_ref  (victim_ref),
    .rd_dirty(victim_dirty)
  );

  xlat_victim #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .advance   (fill_take),
    .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      miss        <= 1'b0;
      miss_vpn    <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_ppn   <= '0;
      evict_ref   <= 1'b0;
      evict_dirty <= 1'b0;
      pend_vpn    <= '0;
      pend_off    <= '0;
      pend_wr     <= 1'b0;
    end else begin
      rsp_valid   <= 1'b0;
      miss        <= 1'b0;
      evict_valid <= 1'b0;
      if (accept) begin
        if (tag_hit) begin
          rsp_valid <= 1'b1;
          rsp_pa    <= {hit_ppn, req_off};
        end else begin
          miss     <= 1'b1;
          miss_vpn <= req_vpn;
          pend_vpn <= req_vpn;
          pend_off <= req_off;
          pend_wr  <= req_write;
          state_q  <= ST_WAIT;
        end
      end
      if (fill_take) begin
        rsp_valid   <= 1'b1;
        rsp_pa      <= {fill_ppn, pend_off};
        state_q     <= ST_IDLE;
        evict_valid <= victim_live;
        evict_vpn   <= victim_live ? victim_vpn   : '0;
        evict_ppn   <= victim_live ? victim_ppn   : '0;
        evict_ref   <= victim_live && victim_ref;
        evict_dirty <= victim_live && victim_dirty;
      end
    end
  end

  // R4: the miss indication lasts a single cycle
  a_r4_miss_one_cycle: assert property (@(posedge clk) disable iff (rst)
    miss |=> !miss);

  // R4: a miss stops further lookups in the cycle it is shown
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (rst)
    miss |-> !ready);

  // R2: a response and a miss are never shown together
  a_r2_rsp_excludes_miss: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && miss));

  // R8: an export only accompanies the completion of a refill
  a_r8_evict_with_refill: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> (rsp_valid && ready));
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  localparam int N     = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   flush = 1'b0;
  logic                   req_valid = 1'b0;
  logic [VPN_W-1:0]       req_vpn = '0;
  logic [OFF_W-1:0]       req_off = '0;
  logic                   req_write = 1'b0;
  logic                   ready;
  logic                   rsp_valid;
  logic [PPN_W+OFF_W-1:0] rsp_pa;
  logic                   miss;
  logic [VPN_W-1:0]       miss_vpn;
  logic                   fill_valid = 1'b0;
  logic [PPN_W-1:0]       fill_ppn = '0;
  logic                   evict_valid;
  logic [VPN_W-1:0]       evict_vpn;
  logic [PPN_W-1:0]       evict_ppn;
  logic                   evict_ref;
  logic                   evict_dirty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  bit             mv    [N];
  logic [VPN_W-1:0] mvpn [N];
  logic [PPN_W-1:0] mppn [N];
  bit             mref  [N];
  bit             mdirty[N];
  int             rr = 0;

  always #10 clk = ~clk;

  xlat_buffer #(
    .ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
  ) u_xlat_buffer (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off), .req_write(req_write),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .miss(miss), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_ppn(evict_ppn),
    .evict_ref(evict_ref), .evict_dirty(evict_dirty)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int model_hit(input logic [VPN_W-1:0] vpn);
    int h = -1;
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) h = i;
    return h;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return rr;
  endfunction

  function automatic bit model_full();
    for (int i = 0; i < N; i++) if (!mv[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
  endtask

  task automatic do_lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                           input bit wr, input string note);
    int h;
    int v;
    bit full;
    logic [PPN_W-1:0] p;
    h = model_hit(vpn);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_off = off; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (h >= 0) begin
      chk(rsp_valid === 1'b1, {"R2 hit response ", note}, 64'(rsp_valid), 64'd1);
      chk(rsp_pa === {mppn[h], off}, {"R2 physical address ", note}, 64'(rsp_pa), 64'({mppn[h], off}));
      chk(miss === 1'b0, {"R4 no miss on hit ", note}, 64'(miss), 64'd0);
      mref[h] = 1'b1;
      if (wr) mdirty[h] = 1'b1;
    end else begin
      chk(miss === 1'b1, {"R4 miss pulse ", note}, 64'(miss), 64'd1);
      chk(miss_vpn === vpn, {"R4 miss page ", note}, 64'(miss_vpn), 64'(vpn));
      chk(rsp_valid === 1'b0, {"R4 no response on miss ", note}, 64'(rsp_valid), 64'd0);
      chk(ready === 1'b0, {"R4 stall after miss ", note}, 64'(ready), 64'd0);
      // probe a lookup while the refill is pending
      req_valid = 1'b1; req_vpn = vpn ^ 20'h1; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(miss === 1'b0, {"R4 miss lasts one cycle ", note}, 64'(miss), 64'd0);
      chk(rsp_valid === 1'b0, {"R10 stalled lookup ignored ", note}, 64'(rsp_valid), 64'd0);
      chk(ready === 1'b0, {"R10 still waiting ", note}, 64'(ready), 64'd0);
      v    = model_victim();
      full = model_full();
      p    = PPN_W'($urandom);
      fill_valid = 1'b1; fill_ppn = p;
      @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid === 1'b1, {"R5 refill response ", note}, 64'(rsp_valid), 64'd1);
      chk(rsp_pa === {p, off}, {"R5 refill address ", note}, 64'(rsp_pa), 64'({p, off}));
      chk(ready === 1'b1, {"R5 ready after refill ", note}, 64'(ready), 64'd1);
      chk(evict_valid === mv[v], {"R8 export flag ", note}, 64'(evict_valid), 64'(mv[v]));
      if (mv[v]) begin
        chk(evict_vpn === mvpn[v], {"R7 victim page ", note}, 64'(evict_vpn), 64'(mvpn[v]));
        chk(evict_ppn === mppn[v], {"R8 victim frame ", note}, 64'(evict_ppn), 64'(mppn[v]));
        chk(evict_dirty === mdirty[v], {"R3 R6 victim dirty ", note}, 64'(evict_dirty), 64'(mdirty[v]));
        chk(evict_ref === mref[v], {"R6 victim reference ", note}, 64'(evict_ref), 64'(mref[v]));
      end
      if (full) rr = (rr == N - 1) ? 0 : rr + 1;
      mv[v] = 1'b1; mvpn[v] = vpn; mppn[v] = p; mref[v] = 1'b1; mdirty[v] = wr;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      mv[i] = 1'b0; mref[i] = 1'b0; mdirty[i] = 1'b0; mvpn[i] = '0; mppn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ready === 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
    chk(rsp_valid === 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk(miss === 1'b0, "R1 no miss after reset", 64'(miss), 64'd0);
    chk(evict_valid === 1'b0, "R1 no export after reset", 64'(evict_valid), 64'd0);
    do_lookup(20'h00123, 12'habc, 1'b0, "R1 empty buffer misses");

    // fill all slots, then exercise round-robin and dirty export (R7, R3)
    for (int i = 0; i < N; i++) do_lookup(20'h100 + 20'(i), 12'(i), i[0], "R6 fill");
    do_lookup(20'h103, 12'h055, 1'b1, "R3 write hit");
    do_lookup(20'h105, 12'h0aa, 1'b0, "R3 read hit");
    for (int i = 0; i < N + 2; i++) do_lookup(20'h200 + 20'(i), 12'h3c0, 1'b0, "R7 round robin");

    // flush behaviour (R9)
    do_flush();
    do_lookup(20'h203, 12'h011, 1'b1, "R9 after flush");
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vpn = 20'h203; req_off = '0; req_write = 1'b0;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    chk(rsp_valid === 1'b0, "R9 lookup in flush cycle gives no response", 64'(rsp_valid), 64'd0);
    chk(miss === 1'b0, "R9 lookup in flush cycle gives no miss", 64'(miss), 64'd0);
    do_lookup(20'h203, 12'h022, 1'b0, "R9 entry gone");

    // constrained random traffic
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 59) == 0) begin
        do_flush();
      end else begin
        do_lookup(20'($urandom_range(0, 11)), 12'($urandom), bit'($urandom_range(0, 1)), "random");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule